// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block takes one reprogramming request, made of a parent (reference) rate and a target rate, and turns it into an ordered series of register accesses that retune an integer-multiplier PLL. It checks the request first. It then works out the multiplier and its encoded register form, and only after that touches the PLL. The PLL is powered down and loaded with the new multiplier and a unity pre/post divider word. It is then powered up and its lock flag is polled a bounded number of times. The output clock is enabled only if lock is reported.

The register side is a simple single-cycle port. Every write is a one-cycle strobe with address and data. A read presents the address in one cycle, and the read data is taken in the following cycle. The block uses four word offsets:

| Offset | Register |
| --- | --- |
| 0x00 | status |
| 0x04 | control |
| 0x08 | multiplier |
| 0x0C | divider |

A `done` pulse closes every accepted request, and `err` pulses together with `done` when the request failed.

Top module: `pll_prog_seq`

## Requirements
- R1: A request with parent rate below target rate, a zero target rate, or a computed multiplier of zero or above 32768 ends with `done` and `err` and makes no register write.
- R2: The multiplier is ceil(parent / (2 * target)). Values 1 to 32768 are accepted.
- R3: Bits 16:0 of the multiplier word hold the encoded multiplier. 1 encodes as 0x18003 and 2 as 0x10003. Any other value m starts a 15-bit shift value at 0x4000 and applies x = (((x ^ x>>1) & 1) << 14) | (x >> 1) once for each integer from m to 32768 inclusive.
- R4: Bits 21:17 of the multiplier word hold the proportional bandwidth field: m/2+1 for m < 60, else 31. Bits 27:22 hold the integral bandwidth field: 1 above 16384, 2 above 8192, 4 above 2048, 8 from 501. From 60 it is 4*q when 1024/(m+9) leaves a remainder and 4*(q+1) when it divides exactly, with q the quotient. Below 60 it is (m & 0x3c)+4.
- R5: The control register is read once per accepted request. The first write to it sets bit 0 (power-down), clears bits 1 to 4 (bypass, direct-in, direct-out, output enable) and keeps every other bit of the value read.
- R6: With power-down set, the multiplier word is written, then the divider register receives 0x00302062.
- R7: The next control write clears bits 0 to 4 and keeps the other read bits.
- R8: Status bit 0 (lock) is read after each wait of 10 us of clock cycles, with at most 4 reads per request.
- R9: When a read shows lock, the control register is written with bit 4 set, bits 0 to 3 clear and the other read bits kept. `done` then pulses without `err`.
- R10: If the fourth read shows no lock, `done` and `err` pulse and no write with bit 4 set occurs.
- R11: `busy` is high from the cycle after acceptance until `done`. A request raised while `busy` is high is ignored.
- R12: `done` is a single-cycle pulse, and `err` is only ever high with `done`.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request strobe, taken when not busy |
| req_parent | input | RATE_W | parent rate |
| req_target | input | RATE_W | target rate |
| busy | output | 1 | sequence in progress |
| done | output | 1 | end-of-request pulse |
| err | output | 1 | failure flag, valid with done |
| reg_addr | output | ADDR_W | register address |
| reg_wdata | output | DATA_W | write data |
| reg_we | output | 1 | write strobe |
| reg_rdata | input | DATA_W | read data, valid the cycle after the address |

## Verification
The assertions assume the register port returns status data in the cycle after a status address, so that the lock flag seen by the checker is the one the sequencer samples. They also assume nothing outside the block writes the PLL registers during a sequence. The bench keeps to this with a register model that registers its read data one cycle late. It accepts writes only from the block, and its lock flag rises a programmable number of cycles after power-down is cleared. Requests are raised for a single cycle at the falling edge, and the bench reloads the control value only while the block is idle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int MSEL_MAX = 32768;
  localparam logic [31:0] NP_UNITY = 32'h0030_2062;

  localparam int CB_PD     = 0;
  localparam int CB_BYPASS = 1;
  localparam int CB_DIN    = 2;
  localparam int CB_DOUT   = 3;
  localparam int CB_OUTEN  = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_DIV, S_CHECK, S_ENC, S_RD_CTRL, S_CAP_CTRL, S_WR_PD,
    S_WR_MUL, S_WR_NP, S_WR_PU, S_WAIT, S_RD_STAT, S_CHK_STAT, S_WR_EN
  } seq_state_e;

  // proportional bandwidth field from the plain multiplier
  function automatic logic [4:0] band_p(input logic [15:0] m);
    if (m < 16'd60) return 5'(m[15:1] + 15'd1);
    return 5'd31;
  endfunction

  // integral bandwidth field; q is 1024/(m+9), exact marks zero remainder
  function automatic logic [5:0] band_i(input logic [15:0] m,
                                        input logic [10:0] q,
                                        input logic exact);
    if (m > 16'd16384) return 6'd1;
    if (m > 16'd8192)  return 6'd2;
    if (m > 16'd2048)  return 6'd4;
    if (m >= 16'd501)  return 6'd8;
    if (m >= 16'd60)   return exact ? 6'((q + 11'd1) << 2) : 6'(q << 2);
    return 6'({2'b00, m[5:2]} << 2) + 6'd4;
  endfunction

endpackage

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             run_q, run_d, done_q, done_d;
  logic [NUM_W-1:0] sh_q, sh_d, quo_q, quo_d;
  logic [DEN_W-1:0] den_q, den_d, rem_q, rem_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEN_W:0]   trial;
  logic             ge;

  always_comb begin
    trial  = {rem_q, sh_q[NUM_W-1]};
    ge     = (trial >= {1'b0, den_q});
    run_d  = run_q;
    sh_d   = sh_q;
    quo_d  = quo_q;
    den_d  = den_q;
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start) begin
      run_d = 1'b1;
      sh_d  = num;
      den_d = den;
      rem_d = '0;
      quo_d = '0;
      cnt_d = '0;
    end else if (run_q) begin
      rem_d = ge ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
      quo_d = {quo_q[NUM_W-2:0], ge};
      sh_d  = sh_q << 1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(NUM_W - 1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      sh_q   <= sh_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/pll_mdec_encoder.sv
module pll_mdec_encoder
  import pll_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] msel,
  output logic        done,
  output logic [16:0] mdec
);
  logic        run_q, run_d, done_q, done_d;
  logic [14:0] x_q, x_d, x_n;
  logic [15:0] cnt_q, cnt_d;
  logic [16:0] mdec_q, mdec_d;

  always_comb begin
    x_n    = {x_q[0] ^ x_q[1], x_q[14:1]};
    run_d  = run_q;
    x_d    = x_q;
    cnt_d  = cnt_q;
    mdec_d = mdec_q;
    done_d = 1'b0;
    if (start) begin
      case (msel)
        16'd0: begin mdec_d = 17'h0;     done_d = 1'b1; end
        16'd1: begin mdec_d = 17'h18003; done_d = 1'b1; end
        16'd2: begin mdec_d = 17'h10003; done_d = 1'b1; end
        default: begin
          run_d = 1'b1;
          x_d   = 15'h4000;
          cnt_d = msel;
        end
      endcase
    end else if (run_q) begin
      x_d   = x_n;
      cnt_d = cnt_q + 16'd1;
      if (cnt_q == 16'(MSEL_MAX)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
        mdec_d = {2'b00, x_n};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      x_q    <= '0;
      cnt_q  <= '0;
      mdec_q <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      x_q    <= x_d;
      cnt_q  <= cnt_d;
      mdec_q <= mdec_d;
    end
  end

  assign done = done_q;
  assign mdec = mdec_q;
endmodule

// File: rtl/pll_poll_timer.sv
module pll_poll_timer #(
  parameter int CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expired
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    expired = en && (cnt_q == CNT_W'(CYCLES - 1));
    if (!en || expired) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int WAIT_US     = 10,
  parameter int POLL_MAX    = 4,
  parameter int RATE_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h00,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 'h04,
  parameter logic [ADDR_W-1:0] OFS_MUL  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_NP   = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [RATE_W-1:0] req_parent,
  input  logic [RATE_W-1:0] req_target,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int WAIT_CYC = (CLK_FREQ_HZ / 1_000_000) * WAIT_US;
  localparam int SAMP_W   = $clog2(POLL_MAX + 1);
  localparam logic [DATA_W-1:0] M_PD    = DATA_W'(1) << CB_PD;
  localparam logic [DATA_W-1:0] M_OUTEN = DATA_W'(1) << CB_OUTEN;
  localparam logic [DATA_W-1:0] M_MODE  = (DATA_W'(1) << CB_BYPASS) |
                                          (DATA_W'(1) << CB_DIN) |
                                          (DATA_W'(1) << CB_DOUT) | M_OUTEN;

  seq_state_e        st_q, st_d;
  logic [RATE_W-1:0] par_q, par_d, tgt_q, tgt_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [15:0]       msel_q, msel_d;
  logic [SAMP_W-1:0] samp_q, samp_d;
  logic              done_q, done_d, err_q, err_d;
  logic              encf_q, encf_d, self_q, self_d;

  // multiplier division
  logic              mdiv_start, mdiv_done;
  logic [RATE_W-1:0] mquo;
  logic [RATE_W:0]   mrem, mceil;
  logic              bad;

  pll_seq_divider #(.NUM_W(RATE_W), .DEN_W(RATE_W + 1)) u_mdiv (
    .clk(clk), .rst_n(rst_n), .start(mdiv_start),
    .num(req_parent), .den({req_target, 1'b0}),
    .done(mdiv_done), .quo(mquo), .rem(mrem)
  );

  assign mdiv_start = (st_q == S_IDLE) && req_valid;
  assign mceil = {1'b0, mquo} + {{RATE_W{1'b0}}, |mrem};
  assign bad = (par_q < tgt_q) || (tgt_q == '0) || (mceil == '0) ||
               (mceil > (RATE_W + 1)'(MSEL_MAX));

  // encoding and bandwidth division
  logic        enc_start, enc_done, sdiv_done;
  logic [16:0] mdec;
  logic [10:0] squo;
  logic [15:0] srem;

  assign enc_start = (st_q == S_CHECK) && !bad;

  pll_mdec_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .start(enc_start),
    .msel(mceil[15:0]), .done(enc_done), .mdec(mdec)
  );

  pll_seq_divider #(.NUM_W(11), .DEN_W(16)) u_sdiv (
    .clk(clk), .rst_n(rst_n), .start(enc_start),
    .num(11'd1024), .den(mceil[15:0] + 16'd9),
    .done(sdiv_done), .quo(squo), .rem(srem)
  );

  logic [DATA_W-1:0] mul_word;
  assign mul_word = DATA_W'({band_i(msel_q, squo, srem == '0),
                             band_p(msel_q), mdec});

  // lock wait timer
  logic tmr_exp;
  pll_poll_timer #(.CYCLES(WAIT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(st_q == S_WAIT), .expired(tmr_exp)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    par_d  = par_q;
    tgt_d  = tgt_q;
    ctrl_d = ctrl_q;
    msel_d = msel_q;
    samp_d = samp_q;
    encf_d = encf_q | enc_done;
    self_d = self_q | sdiv_done;
    done_d = 1'b0;
    err_d  = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        par_d = req_parent;
        tgt_d = req_target;
        st_d  = S_DIV;
      end
      S_DIV: if (mdiv_done) st_d = S_CHECK;
      S_CHECK: begin
        encf_d = 1'b0;
        self_d = 1'b0;
        samp_d = '0;
        msel_d = mceil[15:0];
        if (bad) begin
          done_d = 1'b1;
          err_d  = 1'b1;
          st_d   = S_IDLE;
        end else begin
          st_d = S_ENC;
        end
      end
      S_ENC:      if (encf_q && self_q) st_d = S_RD_CTRL;
      S_RD_CTRL:  st_d = S_CAP_CTRL;
      S_CAP_CTRL: begin
        ctrl_d = reg_rdata;
        st_d   = S_WR_PD;
      end
      S_WR_PD:    st_d = S_WR_MUL;
      S_WR_MUL:   st_d = S_WR_NP;
      S_WR_NP:    st_d = S_WR_PU;
      S_WR_PU:    st_d = S_WAIT;
      S_WAIT:     if (tmr_exp) st_d = S_RD_STAT;
      S_RD_STAT: begin
        samp_d = samp_q + 1'b1;
        st_d   = S_CHK_STAT;
      end
      S_CHK_STAT: begin
        if (reg_rdata[0]) begin
          st_d = S_WR_EN;
        end else if (samp_q == SAMP_W'(POLL_MAX)) begin
          done_d = 1'b1;
          err_d  = 1'b1;
          st_d   = S_IDLE;
        end else begin
          st_d = S_WAIT;
        end
      end
      S_WR_EN: begin
        done_d = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // register port drive
  always_comb begin
    reg_we    = 1'b0;
    reg_addr  = OFS_CTRL;
    reg_wdata = '0;
    case (st_q)
      S_RD_STAT: reg_addr = OFS_STAT;
      S_WR_PD: begin
        reg_we    = 1'b1;
        reg_wdata = (ctrl_q & ~M_MODE) | M_PD;
      end
      S_WR_MUL: begin
        reg_we    = 1'b1;
        reg_addr  = OFS_MUL;
        reg_wdata = mul_word;
      end
      S_WR_NP: begin
        reg_we    = 1'b1;
        reg_addr  = OFS_NP;
        reg_wdata = DATA_W'(NP_UNITY);
      end
      S_WR_PU: begin
        reg_we    = 1'b1;
        reg_wdata = ctrl_q & ~(M_MODE | M_PD);
      end
      S_WR_EN: begin
        reg_we    = 1'b1;
        reg_wdata = (ctrl_q & ~(M_MODE | M_PD)) | M_OUTEN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      par_q  <= '0;
      tgt_q  <= '0;
      ctrl_q <= '0;
      msel_q <= '0;
      samp_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      encf_q <= 1'b0;
      self_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      par_q  <= par_d;
      tgt_q  <= tgt_d;
      ctrl_q <= ctrl_d;
      msel_q <= msel_d;
      samp_q <= samp_d;
      done_q <= done_d;
      err_q  <= err_d;
      encf_q <= encf_d;
      self_q <= self_d;
    end
  end

  assign busy = (st_q != S_IDLE);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk
  import pll_seq_pkg::*;
#(
  parameter int POLL_MAX = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h00,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 'h04,
  parameter logic [ADDR_W-1:0] OFS_MUL  = 'h08,
  parameter logic [ADDR_W-1:0] OFS_NP   = 'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_rdata
);
  logic       pd_sh, stat_d1, lock_seen;
  logic [3:0] stat_cnt, ctrl_wr_cnt;
  logic       stat_rd, ctrl_wr;

  assign stat_rd = busy && !reg_we && (reg_addr == OFS_STAT);
  assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sh       <= 1'b0;
      stat_d1     <= 1'b0;
      lock_seen   <= 1'b0;
      stat_cnt    <= '0;
      ctrl_wr_cnt <= '0;
    end else begin
      stat_d1 <= stat_rd;
      if (ctrl_wr) pd_sh <= reg_wdata[CB_PD];
      if (!busy) begin
        lock_seen   <= 1'b0;
        stat_cnt    <= '0;
        ctrl_wr_cnt <= '0;
      end else begin
        if (stat_d1 && reg_rdata[0]) lock_seen <= 1'b1;
        if (stat_rd) stat_cnt <= stat_cnt + 4'd1;
        if (ctrl_wr) ctrl_wr_cnt <= ctrl_wr_cnt + 4'd1;
      end
    end
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> busy);                                                  // R11
  AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);                                    // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R12
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);                                                     // R12
  AST_NP_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_NP) |-> (reg_wdata == DATA_W'(NP_UNITY))); // R6
  AST_MUL_WHILE_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == OFS_MUL || reg_addr == OFS_NP)) |-> pd_sh); // R6
  AST_FIRST_CTRL_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wr_cnt == 4'd0) |-> (reg_wdata[4:0] == 5'b00001)); // R5
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (stat_cnt < 4'(POLL_MAX)));                            // R8
  AST_OUTEN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[CB_OUTEN]) |-> lock_seen);                   // R9
endmodule

bind pll_prog_seq pll_prog_seq_chk #(
  .POLL_MAX(POLL_MAX), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFS_STAT(OFS_STAT), .OFS_CTRL(OFS_CTRL), .OFS_MUL(OFS_MUL), .OFS_NP(OFS_NP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .done(done), .err(err), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .reg_rdata(reg_rdata)
);

// File: tb/pll_prog_seq_bench.sv
module pll_prog_seq_bench;
  logic        clk, rst_n, req_valid;
  logic [31:0] req_parent, req_target;
  logic        busy, done, err, reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int total = 0;
  int bad = 0;

  pll_prog_seq u_pll_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_parent(req_parent), .req_target(req_target),
    .busy(busy), .done(done), .err(err),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [7:0] A_STAT = 8'h00, A_CTRL = 8'h04, A_MUL = 8'h08, A_NP = 8'h0C;
  localparam logic [31:0] CTRL_INIT = 32'hA5A5_C0FE;

  // register model
  logic        ld_ctrl, clr_log;
  logic [31:0] ld_val, ctrl_mem;
  int          lock_dly, lk_cnt, nwr, stat_reads, done_cnt;
  logic [7:0]  wa [16];
  logic [31:0] wd [16];
  logic        lock;

  assign lock = !ctrl_mem[0] && (lk_cnt >= lock_dly);

  always @(posedge clk) begin
    if (ld_ctrl) ctrl_mem <= ld_val;
    else if (reg_we && reg_addr == A_CTRL) ctrl_mem <= reg_wdata;
    if (reg_we && reg_addr == A_CTRL) lk_cnt <= 0;
    else if (lk_cnt < 1_000_000) lk_cnt <= lk_cnt + 1;
    reg_rdata <= (reg_addr == A_STAT) ? {31'b0, lock} :
                 (reg_addr == A_CTRL) ? ctrl_mem : 32'h0;
    if (clr_log) begin
      nwr <= 0; stat_reads <= 0; done_cnt <= 0;
    end else begin
      if (reg_we) begin
        if (nwr < 16) begin wa[nwr] <= reg_addr; wd[nwr] <= reg_wdata; end
        nwr <= nwr + 1;
      end
      if (busy && !reg_we && reg_addr == A_STAT) stat_reads <= stat_reads + 1;
      if (done) done_cnt <= done_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_mdec(int m);
    int x;
    if (m == 0) return 0;
    if (m == 1) return 'h18003;
    if (m == 2) return 'h10003;
    x = 'h4000;
    for (int i = m; i <= 32768; i++) x = (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 'hffff);
    return x;
  endfunction

  function automatic int ref_mul(int m);
    int p, s, q;
    p = (m < 60) ? (m / 2 + 1) : 31;
    if (m > 16384) s = 1;
    else if (m > 8192) s = 2;
    else if (m > 2048) s = 4;
    else if (m >= 501) s = 8;
    else if (m >= 60) begin
      q = 1024 / (m + 9);
      s = (q * (m + 9) == 1024) ? (q + 1) * 4 : q * 4;
    end else s = (m & 'h3c) + 4;
    return (s << 22) | (p << 17) | ref_mdec(m);
  endfunction

  function automatic int ref_m(longint p, longint t);
    return int'((p + 2 * t - 1) / (2 * t));
  endfunction

  task automatic load_ctrl(input logic [31:0] v);
    @(negedge clk); ld_ctrl = 1'b1; ld_val = v; clr_log = 1'b1;
    @(negedge clk); ld_ctrl = 1'b0; clr_log = 1'b0;
  endtask

  task automatic run_req(input logic [31:0] p, input logic [31:0] t, output bit e);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_parent = p; req_target = t;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 60000) begin @(negedge clk); n++; end
    e = err;
    chk(done, "R11 request completes", done, 1);
    @(negedge clk);
    chk(!done, "R12 done single pulse", done, 0);
  endtask

  task automatic check_success_writes(input int m, input string tag);
    chk(nwr == 5, {tag, " R9 write count"}, nwr, 5);
    chk(wa[0] == A_CTRL && wd[0] == ((CTRL_INIT & ~32'h1E) | 32'h1),
        {tag, " R5 power-down write"}, wd[0], (CTRL_INIT & ~32'h1E) | 32'h1);
    chk(wa[1] == A_MUL && wd[1] == ref_mul(m), {tag, " R3 R4 multiplier word"}, wd[1], ref_mul(m));
    chk(wa[2] == A_NP && wd[2] == 32'h0030_2062, {tag, " R6 divider word"}, wd[2], 32'h0030_2062);
    chk(wa[3] == A_CTRL && wd[3] == (CTRL_INIT & ~32'h1F), {tag, " R7 power-up write"},
        wd[3], CTRL_INIT & ~32'h1F);
    chk(wa[4] == A_CTRL && wd[4] == ((CTRL_INIT & ~32'h1F) | 32'h10), {tag, " R9 enable write"},
        wd[4], (CTRL_INIT & ~32'h1F) | 32'h10);
  endtask

  task automatic t_reset;
    chk(!busy, "R11 idle after reset", busy, 0);
    chk(!done && !err, "R12 no done after reset", {done, err}, 0);
    chk(!reg_we, "R11 no write after reset", reg_we, 0);
  endtask

  task automatic t_fast_lock;
    bit e;
    lock_dly = 200;
    load_ctrl(CTRL_INIT);
    run_req(65534, 1, e);
    chk(!e, "R9 fast lock no err", e, 0);
    chk(ref_m(65534, 1) == 32767, "R2 reference multiplier", ref_m(65534, 1), 32767);
    check_success_writes(32767, "fast");
    chk(stat_reads == 1, "R8 one status read", stat_reads, 1);
  endtask

  task automatic t_no_lock;
    bit e;
    lock_dly = 100_000_000;
    load_ctrl(CTRL_INIT);
    run_req(65536, 1, e);
    chk(e, "R10 no lock gives err", e, 1);
    chk(nwr == 4, "R10 no enable write", nwr, 4);
    chk(wd[1] == ref_mul(32768), "R2 R3 boundary multiplier 32768", wd[1], ref_mul(32768));
    chk(wd[3][4] == 1'b0, "R10 output enable stays off", wd[3][4], 0);
    chk(stat_reads == 4, "R8 four status reads", stat_reads, 4);
  endtask

  task automatic t_late_lock;
    bit e;
    int m;
    m = ref_m(100_000_003, 1526);
    lock_dly = 3000;
    load_ctrl(CTRL_INIT);
    run_req(100_000_003, 1526, e);
    chk(!e, "R9 late lock no err", e, 0);
    chk(m == 32766, "R2 ceiling rounds up", m, 32766);
    check_success_writes(m, "late");
    chk(stat_reads == 3, "R8 lock on third read", stat_reads, 3);
  endtask

  task automatic t_reject(input logic [31:0] p, input logic [31:0] t, input string tag);
    bit e;
    lock_dly = 200;
    load_ctrl(CTRL_INIT);
    run_req(p, t, e);
    chk(e, {tag, " R1 rejected"}, e, 1);
    chk(nwr == 0, {tag, " R1 no writes"}, nwr, 0);
  endtask

  task automatic t_busy_ignore;
    bit e;
    int n;
    lock_dly = 200;
    load_ctrl(CTRL_INIT);
    @(negedge clk);
    req_valid = 1'b1; req_parent = 65534; req_target = 1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R11 busy during sequence", busy, 1);
    req_valid = 1'b1; req_parent = 1; req_target = 5;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 60000) begin @(negedge clk); n++; end
    e = err;
    repeat (5) @(negedge clk);
    chk(!e, "R11 second request ignored, no err", e, 0);
    chk(done_cnt == 1, "R11 single completion", done_cnt, 1);
    check_success_writes(32767, "busy");
  endtask

  task automatic t_small(input logic [31:0] p, input int m, input string tag);
    bit e;
    lock_dly = 200;
    load_ctrl(CTRL_INIT);
    run_req(p, 1, e);
    chk(!e, {tag, " R2 small multiplier accepted"}, e, 0);
    chk(wd[1] == ref_mul(m), {tag, " R3 R4 small multiplier word"}, wd[1], ref_mul(m));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_parent = '0; req_target = '0;
    ld_ctrl = 1'b0; ld_val = '0; clr_log = 1'b1; lock_dly = 200;
    lk_cnt = 0; ctrl_mem = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_lock();
    t_no_lock();
    t_late_lock();
    t_reject(5, 6, "below");
    t_reject(65538, 1, "over");
    t_reject(10, 0, "zero");
    t_busy_ignore();
    t_small(4, 2, "m2");
    t_small(2, 1, "m1");
    t_small(238, 119, "m119");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule